// File: doc/BRIEF.md
# Token-Pointer Register FIFO

This block is a small first-in first-out buffer built from a bank of fixed register slots. A word is written into a slot and stays there until it is read; no data ever moves from one slot to another. The write position and the read position are each a single set bit rotating around a ring of flops. Each of these tokens selects one slot directly, so no address decoder is needed. Because the words stay in place, an access changes only the token flops and at most one slot, which keeps switching activity low.

It sits between two processing units that each run only when they have work. The producer writes while `full` is low and the consumer reads while `empty` is low. A unit that finds its input empty or its output full holds back and stands by. A read and a write may be presented together in one cycle. When neither is accepted, `idle` is high and every internal register keeps its value, so `idle` can drive clock gating for the buffer.

Top module: `token_ring_fifo`

## Requirements
- R1: While `rstN` is low and after it is released, `empty` is 1, `full` is 0 and `rdData` is 0. Both tokens select slot 0.
- R2: Words leave the buffer in the order they were accepted. A word appears on `rdData` one cycle after the accepted read that removed it.
- R3: `full` is 1 exactly when DEPTH words are held, and `empty` is 1 exactly when none are held. The two are never 1 together.
- R4: A write presented while `full` is 1 and `rdEn` is 0 is dropped. The held words and their order do not change.
- R5: A read presented while `empty` is 1 is dropped. `rdData` keeps its previous value and the word count does not change.
- R6: A read and a write accepted in the same cycle leave the word count unchanged.
- R7: A read and a write presented together while `full` is 1 are both accepted. The buffer stays full, and the read returns the oldest word, not the one being written.
- R8: `idle` is 1 in a cycle exactly when neither a write nor a read is accepted. In that cycle no token and no `rdData` changes.
- R9: `rdData` changes only on the edge that ends a cycle with an accepted read. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Word to write |
| full | output | 1 | All slots hold data |
| rdEn | input | 1 | Read request |
| rdData | output | WIDTH | Last word read (registered) |
| empty | output | 1 | No slot holds data |
| idle | output | 1 | No access accepted this cycle; internal state holds |

## Verification
The embedded properties assume that `wrEn` and `rdEn` are known (never X) whenever reset is high. They also assume DEPTH is at least two, so that a token rotation always moves the bit.

The stimulus changes inputs only on falling edges, so every request is stable across the sampling edge. The bench deliberately requests writes while full and reads while empty, because the requirements define those cases as dropped and the properties check that the state holds. The random phases vary the read and write probabilities, so the buffer spends long stretches at both boundaries.

// File: rtl/token_fifo_pkg.sv
package token_fifo_pkg;

  // Strobes from control to datapath: accepted accesses this cycle.
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } fifoStrobe_t;

endpackage

// File: rtl/token_fifo_ctrl.sv
module token_fifo_ctrl
  import token_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  output logic             full,
  output logic             empty,
  output logic             idle,
  output fifoStrobe_t      strobe,
  output logic [DEPTH-1:0] wrTok,
  output logic [DEPTH-1:0] rdTok
);

  localparam int LAST = DEPTH - 1;
  localparam logic [DEPTH-1:0] TOK_INIT = {{(DEPTH-1){1'b0}}, 1'b1};

  logic wrWrap;
  logic rdWrap;
  logic sameSlot;

  assign sameSlot = (wrTok == rdTok);
  assign empty    = sameSlot && (wrWrap == rdWrap);
  assign full     = sameSlot && (wrWrap != rdWrap);

  always_comb begin
    strobe.doRead  = rdEn && !empty;
    strobe.doWrite = wrEn && (!full || rdEn);
  end

  assign idle = !(strobe.doWrite || strobe.doRead);

  // Write token ring: rotates by one on each accepted write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrTok  <= TOK_INIT;
      wrWrap <= 1'b0;
    end else if (strobe.doWrite) begin
      wrTok <= {wrTok[DEPTH-2:0], wrTok[LAST]};
      if (wrTok[LAST]) wrWrap <= ~wrWrap;
    end
  end

  // Read token ring: rotates by one on each accepted read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdTok  <= TOK_INIT;
      rdWrap <= 1'b0;
    end else if (strobe.doRead) begin
      rdTok <= {rdTok[DEPTH-2:0], rdTok[LAST]};
      if (rdTok[LAST]) rdWrap <= ~rdWrap;
    end
  end

  a_r1_wr_token_single: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrTok) == 1);
  a_r1_rd_token_single: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rdTok) == 1);
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn && !rdEn) |=> (full && $stable(wrTok) && $stable(rdTok)));
  a_r5_empty_read_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn && !wrEn) |=> (empty && $stable(rdTok)));
  a_r6_both_keeps_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && !empty && !full) |=> (!empty && !full));
  a_r7_full_both_stays_full: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn && rdEn) |=> full);
  a_r8_idle_holds_tokens: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> ($stable(wrTok) && $stable(rdTok)));

endmodule

// File: rtl/token_fifo_data.sv
module token_fifo_data
  import token_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [DEPTH-1:0] wrTok,
  input  logic [DEPTH-1:0] rdTok,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] slotMem [DEPTH];
  logic [WIDTH-1:0] headWord;

  // Each slot loads only when the write token sits on it.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.doWrite && wrTok[gi]) slotMem[gi] <= wrData;
    end
  end

  // One-hot AND-OR selection of the slot under the read token.
  always_comb begin
    headWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      headWord = headWord | (slotMem[i] & {WIDTH{rdTok[i]}});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.doRead) rdData <= headWord;
  end

  a_r9_rddata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doRead |=> $stable(rdData));
  a_r2_write_needs_token: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrite |-> ($countones(wrTok) == 1));

endmodule

// File: rtl/token_ring_fifo.sv
module token_ring_fifo
  import token_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             full,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             idle
);

  fifoStrobe_t      strobe;
  logic [DEPTH-1:0] wrTok;
  logic [DEPTH-1:0] rdTok;

  token_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .full  (full),
    .empty (empty),
    .idle  (idle),
    .strobe(strobe),
    .wrTok (wrTok),
    .rdTok (rdTok)
  );

  token_fifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrTok (wrTok),
    .rdTok (rdTok),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: tb/token_ring_fifo_tb_top.sv
`timescale 1ns/1ps
module token_ring_fifo_tb_top;

  localparam int DEPTH = 8;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic             rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic             full, empty, idle;

  int checks = 0;
  int fails  = 0;
  logic [WIDTH-1:0] model [$];
  logic [WIDTH-1:0] expRd = '0;
  logic [WIDTH-1:0] nextWord = 16'h1000;

  always #2.5 clk = ~clk;

  token_ring_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .full(full),
    .rdEn(rdEn), .rdData(rdData), .empty(empty), .idle(idle)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: check state left by the last edge, drive, check idle, advance model.
  task automatic step(input logic we, input logic re);
    logic expFull, expEmpty, accW, accR;
    @(negedge clk);
    expFull  = (model.size() == DEPTH);
    expEmpty = (model.size() == 0);
    check("R3 full",  {31'b0, full},  {31'b0, expFull});
    check("R3 empty", {31'b0, empty}, {31'b0, expEmpty});
    check("R2/R9 rdData", {16'b0, rdData}, {16'b0, expRd});
    wrEn   = we;
    rdEn   = re;
    wrData = nextWord;
    accR = re && !expEmpty;               // R5 read on empty dropped
    accW = we && (!expFull || re);        // R4 dropped, R7 accepted
    #0.5;
    check("R8 idle", {31'b0, idle}, {31'b0, !(accW || accR)});
    if (accR) expRd = model.pop_front();  // R7: oldest word before overwrite
    if (accW) begin
      model.push_back(nextWord);
      nextWord = nextWord + 16'h0013;
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 empty in reset", {31'b0, empty}, 32'd1);
    check("R1 full in reset",  {31'b0, full},  32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", {16'b0, rdData}, 32'd0);
    check("R1 empty after reset",  {31'b0, empty},  32'd1);

    // R5: reads on empty, rdData must hold at 0.
    repeat (3) step(1'b0, 1'b1);
    // R3: fill to full.
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0);
    // R4: writes on full dropped.
    repeat (3) step(1'b1, 1'b0);
    // R7: simultaneous access while full.
    repeat (2 * DEPTH + 3) step(1'b1, 1'b1);
    // R8: idle cycles.
    repeat (4) step(1'b0, 1'b0);
    // R2: drain in order, then R5 again.
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 1'b1);
    // R6: write and read together on empty, then at mid fill.
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    repeat (5) step(1'b1, 1'b1);

    // Random phases with varying pressure.
    for (int ph = 0; ph < 6; ph++) begin
      int wp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
      int rp = (ph % 3 == 0) ? 30 : (ph % 3 == 1) ? 80 : 55;
      for (int c = 0; c < 400; c++) begin
        step(($urandom % 100) < wp, ($urandom % 100) < rp);
      end
    end
    repeat (DEPTH + 2) step(1'b0, 1'b1);
    step(1'b0, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule